// File: doc/BRIEF.md
# Ingress Grant Admission Checker

This block sits at the ingress of a shared-memory switch. It judges each arriving packet header against the flow-control grants that were last advertised to the attached devices, and decides whether the packet is taken in or dropped. Two memory grants are supplied, one for each half of the input ports. Two output-queue grant tables are also supplied, one for the element pair that serves each half. Each table holds one bit per destination output and priority.

A unicast packet needs two grants: the memory grant of its input half and the output-queue grant for its destination and priority in that half's table. A multicast packet needs only the memory grant. Per-priority multicast grants are status for the sender and play no part in admission. A header is taken with a valid/ready handshake. The verdict comes out one cycle later and waits until the consumer takes it. Drops are counted by cause in two saturating counters. Software reads a counter through a select and a read strobe, and the read clears it.

Top module: `ingress_grant_admit`

## Requirements
- R1: A unicast header (pkt_mcast=0) is accepted only when the memory grant of its input half is 1 and the output-queue grant bit at index dest*NUM_PRIO+prio of that half's table is 1.
- R2: A multicast header (pkt_mcast=1) is accepted whenever the memory grant of its input half is 1, whatever the output-queue tables hold.
- R3: Input ports below NUM_PORTS/2 use mem_grant[0] and oq_grant_lo. All other ports use mem_grant[1] and oq_grant_hi.
- R4: A header taken on a clock edge (pkt_valid and pkt_ready both 1) shows up as dec_valid=1 right after that edge. While dec_ready is 0, dec_valid, dec_accept and dec_cause hold their values.
- R5: pkt_ready is 1 exactly when no verdict is pending or the pending verdict is being taken (dec_ready=1).
- R6: dec_cause is 2'b00 for an accepted packet, 2'b01 for a drop caused by a missing memory grant, and 2'b10 for a unicast drop caused by a missing output-queue grant. A missing memory grant takes precedence. dec_accept is 1 exactly when dec_cause is 2'b00.
- R7: Each taken header with cause 2'b01 adds one to the memory-drop counter. Each taken header with cause 2'b10 adds one to the queue-drop counter.
- R8: A counter at 2**CNT_W-1 stays there on further drops.
- R9: rd_data shows the counter picked by rd_sel (0 for memory drops, 1 for queue drops) in the same cycle. When rd_en=1 that counter is cleared at the edge. If a drop of the same cause arrives on that edge, the counter becomes 1.
- R10: After reset dec_valid is 0 and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Header present |
| pkt_ready | output | 1 | Header can be taken |
| pkt_mcast | input | 1 | 1 for multicast, 0 for unicast |
| pkt_in_port | input | PORT_W | Input port of the packet |
| pkt_dest | input | PORT_W | Destination output (unicast) |
| pkt_prio | input | PRIO_W | Priority |
| mem_grant | input | 2 | Memory grant per input half |
| oq_grant_lo | input | NUM_PORTS*NUM_PRIO | Queue grants of the pair serving the low half |
| oq_grant_hi | input | NUM_PORTS*NUM_PRIO | Queue grants of the pair serving the high half |
| dec_valid | output | 1 | Verdict pending |
| dec_ready | input | 1 | Consumer takes the verdict |
| dec_accept | output | 1 | Packet admitted |
| dec_cause | output | 2 | Verdict cause code |
| rd_en | input | 1 | Counter read strobe (clears the selected counter) |
| rd_sel | input | 1 | Counter select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The hardest state to reach from the ports is a saturated counter that is read and cleared on the same edge as a new drop of its own cause. Random traffic almost never gets there, because reads clear the counters long before they fill up. A directed phase therefore holds both memory grants low, sends more drops than the counter range with no reads, and then strobes the read alongside a further drop. The random phase draws the two halves, grant tables, packet types and consumer stalls so that every cause code, and the precedence between them, shows up many times against a bench model.

// File: rtl/ingress_grant_admit_pkg.sv
package ingress_grant_admit_pkg;

    typedef enum logic [1:0] {
        CAUSE_OK    = 2'b00,
        CAUSE_NOMEM = 2'b01,
        CAUSE_NOOQ  = 2'b10
    } cause_e;

    typedef struct packed {
        logic   accept;
        cause_e cause;
    } verdict_t;

    // Memory grant is checked first; multicast never looks at the queue grant.
    function automatic verdict_t judge(input logic mcast, input logic mem_ok,
                                       input logic oq_ok);
        verdict_t v;
        if (!mem_ok) begin
            v.accept = 1'b0;
            v.cause  = CAUSE_NOMEM;
        end else if (!mcast && !oq_ok) begin
            v.accept = 1'b0;
            v.cause  = CAUSE_NOOQ;
        end else begin
            v.accept = 1'b1;
            v.cause  = CAUSE_OK;
        end
        return v;
    endfunction

endpackage

// File: rtl/admit_eval.sv
module admit_eval
    import ingress_grant_admit_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int NUM_PRIO  = 4,
    parameter int PORT_W    = $clog2(NUM_PORTS),
    parameter int PRIO_W    = $clog2(NUM_PRIO)
) (
    input  logic                          mcast,
    input  logic [PORT_W-1:0]             in_port,
    input  logic [PORT_W-1:0]             dest,
    input  logic [PRIO_W-1:0]             prio,
    input  logic [1:0]                    mem_grant,
    input  logic [NUM_PORTS*NUM_PRIO-1:0] oq_lo,
    input  logic [NUM_PORTS*NUM_PRIO-1:0] oq_hi,
    output logic                          mem_ok,
    output verdict_t                      verdict
);
    localparam int TBL_N = NUM_PORTS * NUM_PRIO;
    localparam int IDX_W = $clog2(TBL_N);
    localparam int HALF  = NUM_PORTS / 2;

    logic             upper;
    logic [IDX_W-1:0] idx;
    logic             oq_ok;

    always_comb begin
        upper   = (in_port >= PORT_W'(HALF));
        idx     = IDX_W'(dest) * IDX_W'(NUM_PRIO) + IDX_W'(prio);
        mem_ok  = upper ? mem_grant[1] : mem_grant[0];
        oq_ok   = upper ? oq_hi[idx] : oq_lo[idx];
        verdict = judge(mcast, mem_ok, oq_ok);
    end

endmodule

// File: rtl/admit_stage.sv
module admit_stage
    import ingress_grant_admit_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    output logic     in_ready,
    input  verdict_t in_verdict,
    output logic     out_valid,
    input  logic     out_ready,
    output verdict_t out_verdict
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_verdict <= '{accept: 1'b0, cause: CAUSE_OK};
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_verdict <= in_verdict;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_verdict)); // R4

    AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R4

    AST_ACCEPT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_verdict.accept == (out_verdict.cause == CAUSE_OK))); // R6

endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                         count <= '0;
        else if (clr)                    count <= inc ? CNT_W'(1) : '0;
        else if (inc && count != CNT_MAX) count <= count + CNT_W'(1);
    end

    AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
        count == CNT_MAX && inc && !clr |=> count == CNT_MAX); // R8

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr && !inc |=> count == '0); // R9

    AST_STEP: assert property (@(posedge clk) disable iff (rst)
        !clr && inc && count != CNT_MAX |=> count == $past(count) + CNT_W'(1)); // R7

endmodule

// File: rtl/ingress_grant_admit.sv
module ingress_grant_admit
    import ingress_grant_admit_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int NUM_PRIO  = 4,
    parameter int CNT_W     = 8,
    parameter int PORT_W    = $clog2(NUM_PORTS),
    parameter int PRIO_W    = $clog2(NUM_PRIO)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          pkt_valid,
    output logic                          pkt_ready,
    input  logic                          pkt_mcast,
    input  logic [PORT_W-1:0]             pkt_in_port,
    input  logic [PORT_W-1:0]             pkt_dest,
    input  logic [PRIO_W-1:0]             pkt_prio,
    input  logic [1:0]                    mem_grant,
    input  logic [NUM_PORTS*NUM_PRIO-1:0] oq_grant_lo,
    input  logic [NUM_PORTS*NUM_PRIO-1:0] oq_grant_hi,
    output logic                          dec_valid,
    input  logic                          dec_ready,
    output logic                          dec_accept,
    output logic [1:0]                    dec_cause,
    input  logic                          rd_en,
    input  logic                          rd_sel,
    output logic [CNT_W-1:0]              rd_data
);
    localparam int N_CNT = 2;

    verdict_t   now_v, held_v;
    logic       mem_ok;
    logic       take;
    logic [CNT_W-1:0] counts [N_CNT];

    admit_eval #(
        .NUM_PORTS(NUM_PORTS), .NUM_PRIO(NUM_PRIO),
        .PORT_W(PORT_W), .PRIO_W(PRIO_W)
    ) u_eval (
        .mcast(pkt_mcast), .in_port(pkt_in_port), .dest(pkt_dest),
        .prio(pkt_prio), .mem_grant(mem_grant), .oq_lo(oq_grant_lo),
        .oq_hi(oq_grant_hi), .mem_ok(mem_ok), .verdict(now_v)
    );

    admit_stage u_stage (
        .clk(clk), .rst(rst),
        .in_valid(pkt_valid), .in_ready(pkt_ready), .in_verdict(now_v),
        .out_valid(dec_valid), .out_ready(dec_ready), .out_verdict(held_v)
    );

    assign take       = pkt_valid && pkt_ready;
    assign dec_accept = held_v.accept;
    assign dec_cause  = held_v.cause;

    // Counter 0 counts memory-grant drops, counter 1 queue-grant drops.
    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        localparam cause_e MY_CAUSE = (g == 0) ? CAUSE_NOMEM : CAUSE_NOOQ;
        logic inc_g, clr_g;
        assign inc_g = take && (now_v.cause == MY_CAUSE);
        assign clr_g = rd_en && (rd_sel == 1'(g));
        drop_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst(rst), .inc(inc_g), .clr(clr_g), .count(counts[g])
        );
    end

    assign rd_data = counts[rd_sel];

    AST_MCAST_ADMIT: assert property (@(posedge clk) disable iff (rst)
        take && pkt_mcast && mem_ok |=> dec_valid && dec_accept); // R2

    AST_NOMEM_DROP: assert property (@(posedge clk) disable iff (rst)
        take && !mem_ok |=> dec_valid && !dec_accept && dec_cause == 2'b01); // R6

endmodule

// File: tb/ingress_grant_admit_bench.sv
module ingress_grant_admit_bench;
    localparam int NP = 32, NQ = 4, CW = 8, PW = 5, QW = 2, TN = NP * NQ;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst = 1'b1;
    logic pkt_valid = 0, pkt_ready, pkt_mcast = 0;
    logic [PW-1:0] pkt_in_port = '0, pkt_dest = '0;
    logic [QW-1:0] pkt_prio = '0;
    logic [1:0] mem_grant = '0;
    logic [TN-1:0] oq_lo = '0, oq_hi = '0;
    logic dec_valid, dec_ready = 0, dec_accept;
    logic [1:0] dec_cause;
    logic rd_en = 0, rd_sel = 0;
    logic [CW-1:0] rd_data;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    bit m_valid = 0; int m_cause = 0; int m_cnt [2] = '{0, 0};

    always #5 clk = ~clk;

    ingress_grant_admit u_ingress_grant_admit (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_mcast(pkt_mcast), .pkt_in_port(pkt_in_port), .pkt_dest(pkt_dest),
        .pkt_prio(pkt_prio), .mem_grant(mem_grant), .oq_grant_lo(oq_lo),
        .oq_grant_hi(oq_hi), .dec_valid(dec_valid), .dec_ready(dec_ready),
        .dec_accept(dec_accept), .dec_cause(dec_cause), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // R1 R2 R3 R6 expected cause
    function automatic int exp_cause(input bit mc, input int port, input int dst,
                                     input int pr, input logic [1:0] mg,
                                     input logic [TN-1:0] lo, input logic [TN-1:0] hi);
        bit up = (port >= NP / 2);
        bit m  = up ? mg[1] : mg[0];
        bit q  = up ? hi[dst * NQ + pr] : lo[dst * NQ + pr];
        if (!m) return 1;
        if (!mc && !q) return 2;
        return 0;
    endfunction

    // one clock: inputs already set after negedge
    task automatic step(input string tag);
        int c; bit tk; bit rdy;
        #1;
        rdy = !m_valid || dec_ready;
        chk("R5", pkt_ready, rdy);
        chk("R9", rd_data, m_cnt[rd_sel]);
        c  = exp_cause(pkt_mcast, pkt_in_port, pkt_dest, pkt_prio, mem_grant, oq_lo, oq_hi);
        tk = pkt_valid && rdy;
        if (rd_en) m_cnt[rd_sel] = 0;
        if (tk && c != 0 && m_cnt[c - 1] < CMAX) m_cnt[c - 1]++;
        if (rdy) begin
            m_valid = tk;
            if (tk) m_cause = c;
        end
        @(posedge clk); #1;
        chk("R4", dec_valid, m_valid);
        if (m_valid) begin
            chk({"R6 ", tag}, dec_cause, m_cause);
            chk("R6", dec_accept, m_cause == 0);
        end
        @(negedge clk);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10", dec_valid, 0);
        rd_sel = 0; #1; chk("R10", rd_data, 0);
        rd_sel = 1; #1; chk("R10", rd_data, 0);
        @(negedge clk);

        // directed: R3 low half uses table lo, high half uses hi
        dec_ready = 1; pkt_valid = 1; pkt_mcast = 0; mem_grant = 2'b11;
        oq_lo = '0; oq_hi = '0; oq_lo[5 * NQ + 2] = 1'b1;
        pkt_dest = 5; pkt_prio = 2; pkt_in_port = 3;  step("R3 low ok");   // R1 accept
        pkt_in_port = 20;                              step("R3 high miss"); // R3 cause 2
        mem_grant = 2'b10; pkt_in_port = 3;            step("R3 mem lo");   // cause 1
        pkt_mcast = 1; mem_grant = 2'b11; pkt_in_port = 31; step("R2 mcast"); // accept
        // R4 stall hold
        dec_ready = 0; pkt_mcast = 0; pkt_in_port = 16; step("R4 stall");
        step("R4 stall2");
        dec_ready = 1; step("R4 release");

        // directed: R8 saturation on memory-drop counter
        mem_grant = 2'b00; rd_sel = 0; pkt_mcast = 0;
        for (int i = 0; i < CMAX + 40; i++) step("R8 fill");
        chk("R8", rd_data, CMAX);
        rd_en = 1; step("R9 read+drop");               // counter -> 1
        rd_en = 0; pkt_valid = 0; step("R9 after");
        chk("R9", rd_data, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            pkt_valid   = ($urandom % 4) != 0;
            pkt_mcast   = ($urandom % 3) == 0;
            pkt_in_port = PW'($urandom);
            pkt_dest    = PW'($urandom);
            pkt_prio    = QW'($urandom);
            mem_grant   = (($urandom % 4) == 0) ? 2'($urandom) : 2'b11;
            oq_lo       = {$urandom, $urandom, $urandom, $urandom};
            oq_hi       = {$urandom, $urandom, $urandom, $urandom};
            dec_ready   = ($urandom % 4) != 0;
            rd_en       = ($urandom % 16) == 0;
            rd_sel      = 1'($urandom);
            step("R1 R7 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule